// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides when a sensor front end converts and which input the converter samples. A 3-bit channel field picks the on-chip temperature channel or one of four external analog inputs. A mode bit picks between two ways of starting conversions. In the first, conversions run on their own at a fixed 355 µs period. In the second, each rising edge on an external convert pin starts one conversion. The converter itself is a behavioural partner outside the block. The sequencer sends it a one-cycle start pulse together with the selected channel, and the converter answers with a one-cycle done pulse that carries a 10-bit code.

On each accepted done pulse the code is written in one step into a 16-bit result register. The code is left-justified, so one code step is one reference-voltage/1024 step in bits 15:6. Software reaches the two configuration registers through a parallel write port, and reaches them and the result register through a combinational read port. The conversion period is derived from a clock-frequency parameter. The convert pin passes through a parameterised synchroniser.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, the configuration register (address 1) reads 0x0000, so channel 000 (temperature) is selected. The mode register (address 5) reads 0x0000, so free-running mode is active. The result register (address 4) reads 0x0000. The start pulse and the busy flag are low.
- R2: The channel code is bits 7:5 of the configuration register at address 1, and the other bits read 0. Code 000 is the temperature channel, codes 001 to 011 are analog inputs 1 to 3, and code 100 is analog input 4. Every conversion presents the stored code on the channel output during its start pulse.
- R3: A write to address 1 with a channel code of 101, 110 or 111 is discarded, and the previously stored code stays in place.
- R4: The mode register at address 5 is 8 bits. Bit 7 is the trigger mode (0 = free-running, 1 = pin-triggered). Bit 6 is a test bit that is stored and read back but has no other effect. Bits 5:0 always read 0.
- R5: In free-running mode, consecutive start pulses are exactly PERIOD_CYC = CLK_KHZ*355/1000 clock cycles apart, which is 355 µs.
- R6: In pin-triggered mode, no periodic starts occur. A rising edge on the convert pin starts exactly one conversion, and that conversion starts within SYNC_STAGES+2 cycles.
- R7: A convert-pin edge that arrives while a conversion is in progress (busy high) is ignored, and no second start is issued for it.
- R8: When a done pulse arrives during a conversion, the result register at address 4 reads code<<6. The 10-bit code sits in bits 15:6 and bits 5:0 read 0.
- R9: The result register changes only on a done pulse that arrives while busy. A done pulse with no conversion in progress leaves the result unchanged.
- R10: The channel output stays at the value captured at start until the conversion completes, even if the configuration register is rewritten in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Combinational read data |
| conv_pin_i | input | 1 | External convert request pin (asynchronous) |
| adc_start_o | output | 1 | One-cycle converter start pulse |
| adc_chan_o | output | 3 | Channel presented to the converter |
| adc_done_i | input | 1 | One-cycle converter completion pulse |
| adc_code_i | input | 10 | Converter result code, valid with done |
| busy_o | output | 1 | Conversion in progress |

## Verification
The assertions check four things on every cycle. The stored channel code never leaves the legal range. The period counter stays within its terminal count. No start is issued while a conversion is in progress. The result register and the channel output stay stable apart from their permitted update events. Only the bench's scenarios can show the rest: the exact free-running period in cycles, the left-justified packing of specific codes, the readback of the mode and test bits, and the rejection of illegal channel codes. The same holds for the behaviour when the pin is pulsed again in the middle of a conversion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
   localparam int unsigned ADDR_W  = 3;
   localparam int unsigned WDATA_W = 8;
   localparam int unsigned REG_W   = 16;
   localparam int unsigned CHAN_W  = 3;

   localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
   localparam logic [ADDR_W-1:0] A_RES  = 3'd4;
   localparam logic [ADDR_W-1:0] A_MODE = 3'd5;

   localparam logic [CHAN_W-1:0] CHAN_LAST = 3'd4;

   // bit positions decoded by the channel field and mode register
   localparam int unsigned CHAN_LSB = 5;
   localparam int unsigned MODE_BIT = 7;
   localparam int unsigned TEST_BIT = 6;
endpackage

// File: rtl/conv_seq_regs.sv
module conv_seq_regs
   import conv_seq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [WDATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   input  logic [REG_W-1:0]   result_i,
   output logic [REG_W-1:0]   rd_data_o,
   output logic [CHAN_W-1:0]  chan_o,
   output logic               pin_mode_o
);
   logic [CHAN_W-1:0] chan_q;
   logic              mode_q;
   logic              test_q;
   logic [CHAN_W-1:0] chan_wr;
   logic              chan_ok;

   assign chan_wr = wr_data_i[CHAN_LSB +: CHAN_W];
   assign chan_ok = (chan_wr <= CHAN_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q <= '0;
         mode_q <= 1'b0;
         test_q <= 1'b0;
      end else if (wr_en_i) begin
         if (wr_addr_i == A_CFG && chan_ok) chan_q <= chan_wr;
         if (wr_addr_i == A_MODE) begin
            mode_q <= wr_data_i[MODE_BIT];
            test_q <= wr_data_i[TEST_BIT];
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         A_CFG:  rd_data_o[CHAN_LSB +: CHAN_W] = chan_q;
         A_MODE: begin
            rd_data_o[MODE_BIT] = mode_q;
            rd_data_o[TEST_BIT] = test_q;
         end
         A_RES:  rd_data_o = result_i;
         default: rd_data_o = '0;
      endcase
   end

   assign chan_o     = chan_q;
   assign pin_mode_o = mode_q;

   p_chan_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chan_q <= CHAN_LAST);

   p_reject_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == A_CFG && wr_data_i[CHAN_LSB +: CHAN_W] > CHAN_LAST)
      |=> $stable(chan_q));
endmodule

// File: rtl/conv_seq_trig.sv
module conv_seq_trig #(
   parameter int unsigned PERIOD_CYC  = 35500,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_mode_i,
   input  logic conv_pin_i,
   input  logic busy_i,
   output logic fire_o
);
   localparam int unsigned CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             pin_s;
   logic             pin_prev_q;
   logic             tick;
   logic             edge_seen;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = conv_pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= (sync_q << 1) | SYNC_STAGES'(conv_pin_i);
         end
         assign pin_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         pin_prev_q <= 1'b0;
      end else begin
         pin_prev_q <= pin_s;
         if (pin_mode_i || cnt_q == CNT_LAST) cnt_q <= '0;
         else                                 cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick      = !pin_mode_i && (cnt_q == CNT_LAST);
   assign edge_seen = pin_mode_i && pin_s && !pin_prev_q;
   assign fire_o    = (tick || edge_seen) && !busy_i;

   p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);

   p_pin_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_mode_i |=> (cnt_q == '0));
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
   import conv_seq_pkg::*;
#(
   parameter int unsigned RES_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic              adc_done_i,
   input  logic [RES_W-1:0]  adc_code_i,
   output logic              adc_start_o,
   output logic [CHAN_W-1:0] adc_chan_o,
   output logic              busy_o,
   output logic [REG_W-1:0]  result_o
);
   localparam int unsigned PAD_W = REG_W - RES_W;

   logic              busy_q;
   logic              start_q;
   logic [CHAN_W-1:0] chan_q;
   logic [REG_W-1:0]  result_q;
   logic              accept;

   assign accept = adc_done_i && busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         start_q  <= 1'b0;
         chan_q   <= '0;
         result_q <= '0;
      end else begin
         start_q <= fire_i;
         if (fire_i) begin
            busy_q <= 1'b1;
            chan_q <= chan_i;
         end else if (accept) begin
            busy_q <= 1'b0;
         end
         if (accept) begin
            result_q <= {adc_code_i, PAD_W'(0)};
         end
      end
   end

   assign adc_start_o = start_q;
   assign adc_chan_o  = chan_q;
   assign busy_o      = busy_q;
   assign result_o    = result_q;

   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !adc_done_i) |=> !adc_start_o);

   p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(result_q));

   p_chan_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !adc_done_i) |=> $stable(adc_chan_o));

   p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      result_q[PAD_W-1:0] == '0);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
   import conv_seq_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 100_000,
   parameter int unsigned PERIOD_NS   = 355_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RES_W       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [2:0]        rd_addr_i,
   output logic [15:0]       rd_data_o,
   input  logic              conv_pin_i,
   output logic              adc_start_o,
   output logic [2:0]        adc_chan_o,
   input  logic              adc_done_i,
   input  logic [RES_W-1:0]  adc_code_i,
   output logic              busy_o
);
   localparam longint unsigned PERIOD_L =
      (longint'(CLK_KHZ) * longint'(PERIOD_NS)) / 64'd1_000_000;
   localparam int unsigned PERIOD_CYC = int'(PERIOD_L);

   generate
      if (PERIOD_CYC < 2) begin : g_bad_period
         $error("conv_sequencer: period below two cycles");
      end
      if (RES_W < 1 || RES_W >= REG_W) begin : g_bad_res
         $error("conv_sequencer: result width must fit below register width");
      end
   endgenerate

   logic [CHAN_W-1:0] chan_sel;
   logic              pin_mode;
   logic              fire;
   logic              busy;
   logic [REG_W-1:0]  result;

   conv_seq_regs i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .rd_addr_i  (rd_addr_i),
      .result_i   (result),
      .rd_data_o  (rd_data_o),
      .chan_o     (chan_sel),
      .pin_mode_o (pin_mode)
   );

   conv_seq_trig #(
      .PERIOD_CYC  (PERIOD_CYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_mode_i (pin_mode),
      .conv_pin_i (conv_pin_i),
      .busy_i     (busy),
      .fire_o     (fire)
   );

   conv_seq_ctrl #(
      .RES_W (RES_W)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_i      (fire),
      .chan_i      (chan_sel),
      .adc_done_i  (adc_done_i),
      .adc_code_i  (adc_code_i),
      .adc_start_o (adc_start_o),
      .adc_chan_o  (adc_chan_o),
      .busy_o      (busy),
      .result_o    (result)
   );

   assign busy_o = busy;
endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
   localparam int CLK_KHZ = 1000;
   localparam int PERIOD  = CLK_KHZ * 355 / 1000;
   localparam int SYNC    = 2;
   localparam int LAT     = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        conv_pin = 1'b0;
   logic        adc_start;
   logic [2:0]  adc_chan;
   logic        adc_done = 1'b0;
   logic [9:0]  adc_code = '0;
   logic        busy;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int n_starts = 0;
   int t_last = 0;
   int t_prev = 0;
   int lat = -1;
   int start_chan = 0;
   int code_next = 0;
   bit stray = 0;
   int stray_code = 0;

   always #5 clk = ~clk;

   conv_sequencer #(.CLK_KHZ(CLK_KHZ), .SYNC_STAGES(SYNC)) i_conv_sequencer (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .conv_pin_i(conv_pin), .adc_start_o(adc_start), .adc_chan_o(adc_chan),
      .adc_done_i(adc_done), .adc_code_i(adc_code), .busy_o(busy)
   );

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // behavioural converter: done LAT cycles after each start
   initial forever begin
      @(negedge clk);
      adc_done = 1'b0;
      if (stray) begin
         adc_done = 1'b1;
         adc_code = 10'(stray_code);
         stray = 0;
      end else if (lat == 0) begin
         adc_done = 1'b1;
         adc_code = 10'(code_next);
         lat = -1;
      end else if (lat > 0) begin
         lat--;
      end
      if (adc_start) begin
         n_starts++;
         start_chan = int'(adc_chan);
         t_prev = t_last;
         t_last = cyc;
         lat = LAT - 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input int addr, output int val);
      @(negedge clk); #1;
      rd_addr = 3'(addr);
      #1 val = int'(rd_data);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200; i++) begin
         @(negedge clk); #2;
         if (!busy && lat < 0 && !adc_done) break;
      end
   endtask

   task automatic pulse_pin();
      @(negedge clk); #1;
      conv_pin = 1'b1;
      repeat (4) @(negedge clk);
      #1 conv_pin = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v;
      int s0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(1, v); chk("R1 cfg", v, 0);
      rd(5, v); chk("R1 mode", v, 0);
      rd(4, v); chk("R1 result", v, 0);
      chk("R1 start", int'(adc_start), 0);
      chk("R1 busy", int'(busy), 0);

      // R5 free-running period
      code_next = 700;
      for (int i = 0; i < 5 * PERIOD && n_starts < 3; i++) @(negedge clk);
      chk("R5 starts seen", n_starts >= 3, 1);
      chk("R5 interval", t_last - t_prev, PERIOD);
      for (int i = 0; i < 2 * PERIOD && n_starts < 4; i++) @(negedge clk);
      chk("R5 interval again", t_last - t_prev, PERIOD);
      chk("R2 temp channel at start", start_chan, 0);
      wait_idle();
      rd(4, v); chk("R8 free-run result", v, 700 << 6);

      // switch to pin mode; R6 no periodic starts
      wr(5, 8'h80);
      wait_idle();
      s0 = n_starts;
      repeat (2 * PERIOD + 5) @(negedge clk);
      chk("R6 no periodic start", n_starts, s0);

      // R4 mode register
      wr(5, 8'hFF);
      rd(5, v); chk("R4 mode+test readback", v, 16'h00C0);
      wr(5, 8'hBF);
      rd(5, v); chk("R4 test clear", v, 16'h0080);

      // R2 / R8 / R6 sweep over channels and codes
      for (int c = 0; c < 5; c++) begin
         for (int k = 0; k < 3; k++) begin
            int code;
            code = (k == 0) ? 0 : (k == 1) ? 1023 : ((c * 211 + 97) % 1024);
            code_next = code;
            wr(1, (c << 5) | 8'h1F);
            rd(1, v); chk("R2 cfg readback", v, c << 5);
            s0 = n_starts;
            @(negedge clk); #1 conv_pin = 1'b1;
            repeat (SYNC + 2) @(negedge clk);
            chk("R6 start latency", n_starts, s0 + 1);
            #1 conv_pin = 1'b0;
            wait_idle();
            chk("R6 single start", n_starts, s0 + 1);
            chk("R2 channel at start", start_chan, c);
            rd(4, v); chk("R8 result packing", v, code << 6);
         end
      end

      // R3 illegal channel codes
      wr(1, 8'h40);
      wr(1, 8'hA0);
      rd(1, v); chk("R3 code 5 rejected", v, 16'h0040);
      wr(1, 8'hC0);
      wr(1, 8'hE0);
      rd(1, v); chk("R3 codes 6,7 rejected", v, 16'h0040);

      // R7 pin edge during conversion ignored
      code_next = 333;
      s0 = n_starts;
      pulse_pin();
      chk("R7 busy after first edge", int'(busy), 1);
      @(negedge clk); #1 conv_pin = 1'b1;
      repeat (5) @(negedge clk);
      #1 conv_pin = 1'b0;
      wait_idle();
      repeat (10) @(negedge clk);
      chk("R7 one start only", n_starts, s0 + 1);
      rd(4, v); chk("R7 result", v, 333 << 6);

      // R10 channel held through conversion
      wr(1, 8'h60);
      code_next = 5;
      pulse_pin();
      wr(1, 8'h20);
      #1 chk("R10 channel held", int'(adc_chan), 3);
      repeat (4) @(negedge clk);
      #1 chk("R10 channel still held", int'(adc_chan), 3);
      wait_idle();
      rd(1, v); chk("R10 cfg updated", v, 16'h0020);
      pulse_pin();
      wait_idle();
      chk("R10 new channel used", start_chan, 1);

      // R9 stray done ignored
      rd(4, v); chk("R9 result before", v, 5 << 6);
      @(negedge clk); #1 stray_code = 10'h155; stray = 1;
      repeat (4) @(negedge clk);
      rd(4, v); chk("R9 stray done ignored", v, 5 << 6);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule